// File: doc/BRIEF.md
# FIR chain sequencer

This block is the program-flow controller for a shared FIR compute engine. A small instruction store of `NSTEP` words is loaded from a host port. The controller walks through it one step at a time and decides, each cycle, whether to stall, branch or launch a filter. The filter engine itself and its memories sit outside this block.

Three instruction classes share a 9-bit opcode field. A wait step stalls until enough input samples have arrived. A jump step branches on a condition. A filter/control step can launch the engine, load or decrement a loop counter, and subtract one of two programmed amounts from the input-sample counter. A launched step blocks until the engine answers with a done pulse.

A hold input lets the host load the program safely. While hold is high, host writes are taken and no instruction is executed.

Top module: `fir_chain_seq`

## Requirements
- R1: After reset the instruction pointer is NSTEP-1 (31), the wait and loop counters are zero, `eng_start` is low, and every stored instruction word is zero.
- R2: A host write stores `wr_data` at `wr_addr` only when `hold` is high; a write with `hold` low changes nothing.
- R3: While `hold` is high, no instruction executes: the pointer does not move on its own and no engine start is issued.
- R4: A wait or jump step, or a filter/control step with bit 6 (launch) clear, takes exactly one clock. A non-branching advance from step NSTEP-1 goes to step 0.
- R5: The condition is in bits 2:0. 000 is true when the loop counter is nonzero. 001 is true when it is zero. 010 is true when the wait counter is at least `wait_thresh`. 111 is always true. 011 to 110 are always false.
- R6: A step with bit 8 set is a jump. It moves the pointer to the target in bits 7:3 when its condition holds, and to the next step otherwise.
- R7: A step with bits 8:7 = 00 is a wait. It advances when its condition holds and otherwise stays on the same step.
- R8: A step with bits 8:7 = 01 and bit 6 set raises `eng_start` for one cycle. In that cycle `eng_step` is the pointer value, `eng_resamp` is bit 5 and `eng_mode` is bit 0. The pointer then stays put until `eng_done`, and advances in the cycle that follows it.
- R9: In a filter/control step, bit 2 loads the loop counter from bits 20:9, and wins when bit 1 is also set. Bit 1 alone decrements the loop counter, which stops at zero.
- R10: The wait counter adds one for each cycle with `sample_in` high. In a filter/control step, bit 3 subtracts `decr_a` when bit 4 is 0 and `decr_b` when bit 4 is 1, with the result floored at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hold | input | 1 | Host hold: allows writes, freezes execution |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | AW | Host write step index |
| wr_data | input | IW | Host instruction word |
| sample_in | input | 1 | One input sample arrived this cycle |
| wait_thresh | input | WCNT_W | Wait threshold |
| decr_a | input | WCNT_W | Wait decrement, selector 0 |
| decr_b | input | WCNT_W | Wait decrement, selector 1 |
| eng_done | input | 1 | Engine completion pulse |
| eng_start | output | 1 | Engine launch pulse |
| eng_step | output | AW | Step number sent with the launch |
| eng_resamp | output | 1 | Resampler increment flag sent with the launch |
| eng_mode | output | 1 | Mode flag (bit 0) sent with the launch |
| ip_o | output | AW | Current instruction pointer |
| wait_cnt | output | WCNT_W | Input-sample wait counter |
| loop_cnt | output | LOOP_W | Loop counter |

## Verification
A corrupted pointer shows up on `ip_o` within one clock. A wrong branch decision places the pointer on the wrong step on the next edge. A bad loop or wait count shows up as the wrong number of engine launches once the program settles on its parking step. The bench sweeps the loop preload and the number of input samples over small ranges, and checks launch counts and residual counter values against simple arithmetic. It traces short branch programs cycle by cycle.

// File: rtl/fir_chain_seq.sv
module fir_chain_seq #(
  parameter int NSTEP  = 32,
  parameter int WCNT_W = 16,
  parameter int LOOP_W = 12,
  localparam int AW = $clog2(NSTEP),
  localparam int IW = 9 + LOOP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [IW-1:0]     wr_data,
  input  logic              sample_in,
  input  logic [WCNT_W-1:0] wait_thresh,
  input  logic [WCNT_W-1:0] decr_a,
  input  logic [WCNT_W-1:0] decr_b,
  input  logic              eng_done,
  output logic              eng_start,
  output logic [AW-1:0]     eng_step,
  output logic              eng_resamp,
  output logic              eng_mode,
  output logic [AW-1:0]     ip_o,
  output logic [WCNT_W-1:0] wait_cnt,
  output logic [LOOP_W-1:0] loop_cnt
);

  logic [IW-1:0] mem [NSTEP];
  logic [AW-1:0] ip, ip_nx;
  logic          busy;
  logic          cond;

  function automatic logic [AW-1:0] step_inc(input logic [AW-1:0] p);
    return (p == AW'(NSTEP-1)) ? '0 : p + 1'b1;
  endfunction

  wire [IW-1:0] ins    = mem[ip];
  wire          is_jmp = ins[8];
  wire          is_wt  = ins[8:7] == 2'b00;
  wire          is_fir = ins[8:7] == 2'b01;
  wire          exec   = !hold && !busy;
  wire          launch = exec && is_fir && ins[6];
  wire          do_dec = exec && is_fir && ins[3];
  wire          do_ld  = exec && is_fir && ins[2];
  wire          do_dl  = exec && is_fir && ins[1];

  always_comb begin
    case (ins[2:0])
      3'b000:  cond = loop_cnt != '0;
      3'b001:  cond = loop_cnt == '0;
      3'b010:  cond = wait_cnt >= wait_thresh;
      3'b111:  cond = 1'b1;
      default: cond = 1'b0;
    endcase
  end

  always_comb begin
    ip_nx = ip;
    if (busy) begin
      if (eng_done) ip_nx = step_inc(ip);
    end else if (exec) begin
      if (is_jmp)      ip_nx = cond ? ins[3 +: AW] : step_inc(ip);
      else if (is_wt)  ip_nx = cond ? step_inc(ip) : ip;
      else if (!ins[6]) ip_nx = step_inc(ip);
    end
  end

  logic [WCNT_W:0] w_sum, w_dec, w_sub;
  assign w_sum = {1'b0, wait_cnt} + {{WCNT_W{1'b0}}, sample_in};
  assign w_dec = do_dec ? {1'b0, (ins[4] ? decr_b : decr_a)} : '0;
  assign w_sub = (w_sum >= w_dec) ? w_sum - w_dec : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSTEP; i++) mem[i] <= '0;
    end else if (hold && wr_en && (int'(wr_addr) < NSTEP)) begin
      mem[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ip         <= AW'(NSTEP-1);
      busy       <= 1'b0;
      eng_start  <= 1'b0;
      eng_step   <= '0;
      eng_resamp <= 1'b0;
      eng_mode   <= 1'b0;
      wait_cnt   <= '0;
      loop_cnt   <= '0;
    end else begin
      ip         <= ip_nx;
      eng_start  <= launch;
      eng_resamp <= launch && ins[5];
      eng_mode   <= launch && ins[0];
      if (launch) eng_step <= ip;
      if (launch) busy <= 1'b1;
      else if (busy && eng_done) busy <= 1'b0;
      wait_cnt <= w_sub[WCNT_W] ? '1 : w_sub[WCNT_W-1:0];
      if (do_ld)      loop_cnt <= ins[9 +: LOOP_W];
      else if (do_dl && loop_cnt != '0) loop_cnt <= loop_cnt - 1'b1;
    end
  end

  assign ip_o = ip;

endmodule

module fir_chain_seq_chk #(
  parameter int AW = 5,
  parameter int IW = 21,
  parameter int WCNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hold,
  input logic              busy,
  input logic [IW-1:0]     ins,
  input logic              eng_start,
  input logic              eng_done,
  input logic [AW-1:0]     eng_step,
  input logic [AW-1:0]     ip_o,
  input logic [WCNT_W-1:0] wait_cnt,
  input logic [WCNT_W-1:0] wait_thresh
);
  // R8
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);
  // R8
  start_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> eng_step == ip_o);
  // R8
  busy_ip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !eng_done) |=> $stable(ip_o));
  // R3
  hold_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !eng_start);
  // R6
  jump_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !busy && ins[8] && ins[2:0] == 3'b111) |=> ip_o == $past(ins[3 +: AW]));
  // R7
  wait_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !busy && ins[8:7] == 2'b00 && ins[2:0] == 3'b010 && wait_cnt < wait_thresh)
    |=> $stable(ip_o));
endmodule

bind fir_chain_seq fir_chain_seq_chk #(.AW(AW), .IW(IW), .WCNT_W(WCNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold(hold), .busy(busy), .ins(ins),
  .eng_start(eng_start), .eng_done(eng_done), .eng_step(eng_step),
  .ip_o(ip_o), .wait_cnt(wait_cnt), .wait_thresh(wait_thresh)
);

// File: tb/sim_fir_chain_seq.sv
`timescale 1ns/1ps
module sim_fir_chain_seq;
  logic        clk = 0;
  logic        rst_n = 0, hold = 1, wr_en = 0, sample_in = 0, eng_done = 0;
  logic [4:0]  wr_addr = 0;
  logic [20:0] wr_data = 0;
  logic [15:0] wait_thresh = 4, decr_a = 4, decr_b = 3;
  logic        eng_start, eng_resamp, eng_mode;
  logic [4:0]  eng_step, ip_o;
  logic [15:0] wait_cnt;
  logic [11:0] loop_cnt;

  int checks = 0, fails = 0;
  int starts = 0, dly = 0;
  bit resamp_seen = 0, mode_seen = 0;
  logic [4:0] last_step = 0;

  always #2.5 clk = ~clk;

  fir_chain_seq u0 (.clk, .rst_n, .hold, .wr_en, .wr_addr, .wr_data, .sample_in,
    .wait_thresh, .decr_a, .decr_b, .eng_done, .eng_start, .eng_step,
    .eng_resamp, .eng_mode, .ip_o, .wait_cnt, .loop_cnt);

  // engine model: done two cycles after a start is seen
  always @(negedge clk) begin
    eng_done = 0;
    if (!rst_n) dly = 0;
    else if (eng_start) begin
      starts++; last_step = eng_step;
      if (eng_resamp) resamp_seen = 1;
      if (eng_mode) mode_seen = 1;
      dly = 2;
    end else if (dly > 0) begin
      dly--;
      if (dly == 1) eng_done = 1;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; hold = 1; wr_en = 0; sample_in = 0;
    repeat (2) @(negedge clk);
    rst_n = 1; starts = 0; resamp_seen = 0; mode_seen = 0;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1; wr_addr = 5'(a); wr_data = 21'(d);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse_sample();
    @(negedge clk); sample_in = 1;
    @(negedge clk); sample_in = 0;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 ip", ip_o, 31);
    chk("R1 wait", wait_cnt, 0);
    chk("R1 loop", loop_cnt, 0);
    chk("R1 start", eng_start, 0);

    // R1 memory cleared, R4 wrap 31->0: step 31 is a NOP, step 0 is a zero word (wait on loop!=0)
    wr(31, 'h080);
    @(negedge clk); hold = 0;
    @(negedge clk); chk("R4 wrap to 0", ip_o, 0);
    repeat (5) @(negedge clk); chk("R1 zero word stalls", ip_o, 0);

    // R5 R6 R7 R3: branch trace
    do_reset();
    wr(31, 'h129); wr(5, 'h14B); wr(6, 'h14E); wr(7, 'h004);
    repeat (10) @(negedge clk);
    chk("R3 hold freezes ip", ip_o, 31);
    hold = 0;
    @(negedge clk); chk("R5 R6 cond 001 taken", ip_o, 5);
    @(negedge clk); chk("R5 cond 011 false", ip_o, 6);
    @(negedge clk); chk("R5 cond 110 false", ip_o, 7);
    repeat (6) @(negedge clk); chk("R7 wait false stalls", ip_o, 7);

    // R9 load wins over decrement
    do_reset();
    wr(31, 'h107); wr(0, 'h086 | ('hABC << 9)); wr(1, 'h10F);
    @(negedge clk); hold = 0;
    repeat (6) @(negedge clk);
    chk("R9 loop load", loop_cnt, 'hABC);

    // R8 R9 loop sweep
    for (int n = 0; n <= 6; n++) begin
      do_reset();
      wr(31, 'h107); wr(0, 'h084 | (n << 9)); wr(1, 'h0C3);
      wr(2, 'h108); wr(3, 'h11F);
      @(negedge clk); hold = 0;
      repeat (12 * (n + 1) + 10) @(negedge clk);
      chk($sformatf("R9 launches n=%0d", n), starts, (n < 1) ? 1 : n);
      chk("R8 step number", last_step, 1);
      chk("R8 mode flag", mode_seen, 1);
      chk("R6 parked", ip_o, 3);
      chk("R9 loop end", loop_cnt, 0);
    end
    // R2 write with hold low ignored
    wr(3, 'h0C0);
    repeat (20) @(negedge clk);
    chk("R2 no extra launch", starts, 1 + 5);
    chk("R2 ip unchanged", ip_o, 3);

    // R10 R7 wait counter sweep
    for (int sel = 0; sel < 2; sel++) begin
      for (int k = 0; k <= 9; k++) begin
        int es, ew;
        do_reset();
        wr(31, 'h107); wr(0, 'h002); wr(1, sel ? 'h0F8 : 'h0C8); wr(2, 'h107);
        @(negedge clk); hold = 0;
        for (int j = 0; j < k; j++) pulse_sample();
        repeat (20) @(negedge clk);
        if (sel == 0) begin es = k / 4; ew = k % 4; end
        else begin es = (k < 4) ? 0 : 1 + (k - 4) / 3; ew = k - 3 * es; end
        chk($sformatf("R10 launches sel=%0d k=%0d", sel, k), starts, es);
        chk($sformatf("R10 residual sel=%0d k=%0d", sel, k), wait_cnt, ew);
        chk("R8 resamp flag", resamp_seen, (sel == 1 && es > 0) ? 1 : 0);
        chk("R7 parked at wait", ip_o, 0);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule